// File: doc/BRIEF.md
# Bus Device Liveness Monitor

This block sits behind a master-frame decoder on a vehicle control bus and keeps one record per registered device address. Each decoded master frame presents a function code and a device address for one clock. The monitor looks the address up in a software-loaded registration table. A registered device has its last-heard time refreshed. An address that is not registered raises an unknown-device alarm. A registered device that uses a function code its mask does not allow raises a bad-command alarm.

A background sweeper walks the table one entry per idle clock. It raises an offline alarm for a registered device whose silence, measured in modular 32-bit arithmetic against a free-running time input, is longer than a programmable timeout. Each silence episode gives one offline alarm. The entry re-arms when the device is heard again or when its table entry is rewritten. Alarms go into a show-ahead FIFO. A full FIFO drops new alarms and sets a flag that stays set until reset.

The sweeper is a two-state machine. In SW_PROBE it reads the entry under the sweep index. If that entry has expired it moves to SW_RAISE (transition *expire*). Otherwise it steps the index (transition *step*). In SW_RAISE it checks the entry again, emits the offline alarm if the entry is still expired, steps the index and returns to SW_PROBE (transition *emit*). In either state, a cycle that carries a frame holds the machine where it is (transition *hold*). This lets the table update for the frame settle before the sweeper evaluates the entry.

Top module: `liveness_monitor`

## Requirements
- R1: After reset the alarm FIFO is empty, `alm_lost` is 0 and every table entry is unregistered, so any address seen is reported as unknown.
- R2: A table write (`tbl_we`) stores address, valid bit and a 16-bit code mask at `tbl_idx`. It also stamps that entry's last-heard time with `now_ts` and arms its offline alarm.
- R3: A frame whose address matches no valid entry queues an alarm of kind 2 (unknown) carrying the frame address and `now_ts`. An entry with valid bit 0 never matches.
- R4: A frame from a registered address whose mask bit at index `frame_code` is 0 queues an alarm of kind 3 (bad command) carrying the address and `now_ts`. If that bit is 1, no alarm is queued.
- R5: Any frame from a registered address, allowed code or not, sets that entry's last-heard time to `now_ts` and re-arms its offline alarm. When two valid entries hold the same address, the lower index is the one matched.
- R6: A valid, armed entry for which `now_ts - last_heard` is strictly greater than `timeout` queues an alarm of kind 1 (offline). The alarm carries the entry's address and its last-heard time. An age equal to `timeout` raises nothing.
- R7: An offline alarm is raised once per silence episode. Later sweeps raise nothing more for that entry until R2 or R5 re-arms it.
- R8: Age is computed modulo 2^32, so a last-heard time just below the wrap point and a current time just past it give the true small age.
- R9: The sweeper visits one entry per clock and does not move on cycles that carry a frame. Every entry is evaluated within 2 x ENTRIES frame-free cycles, and offline alarms are only queued on cycles with no frame.
- R10: Alarms leave in arrival order. `alm_valid` shows the head and `alm_pop` removes it. An alarm that arrives while the FIFO holds FIFO_DEPTH entries (and no pop is taking place) is dropped and sets `alm_lost`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe for a decoded master frame |
| frame_code | input | CODE_W (4) | Function code of the frame |
| frame_addr | input | ADDR_W (12) | Device address of the frame |
| now_ts | input | TS_W (32) | Free-running time |
| timeout | input | TS_W (32) | Silence limit; offline when age exceeds it |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W (8) | Entry index to write |
| tbl_addr | input | ADDR_W (12) | Device address for the entry |
| tbl_valid | input | 1 | Entry registered flag |
| tbl_mask | input | 2^CODE_W (16) | Allowed function codes, bit n for code n |
| alm_pop | input | 1 | Remove the head alarm |
| alm_valid | output | 1 | FIFO holds at least one alarm |
| alm_kind | output | 2 | Head alarm kind: 1 offline, 2 unknown, 3 bad command |
| alm_addr | output | ADDR_W (12) | Head alarm device address |
| alm_ts | output | TS_W (32) | Head alarm time (frame time, or last-heard time for offline) |
| alm_lost | output | 1 | Sticky: an alarm was dropped because the FIFO was full |

## Verification
The hardest case to reach from the ports is an offline alarm for exactly one device, at a known moment. The sweeper's position is invisible from outside, and any jump of `now_ts` can expire several devices at once. The stimulus therefore staggers last-heard times with refreshing frames, so that each jump of `now_ts` pushes exactly one device past the limit. It parks `now_ts` exactly at age = timeout before stepping one tick beyond. For the wrap case it raises `timeout` to its maximum while moving time near 2^32, so nothing expires during the move. A behavioural model of the table and FIFO predicts every queued alarm and the lost flag, and the lost flag is compared on every clock.

// File: rtl/liveness_pkg.sv
package liveness_pkg;

    typedef enum logic [1:0] {
        ALM_NONE    = 2'd0,
        ALM_OFFLINE = 2'd1,
        ALM_UNKNOWN = 2'd2,
        ALM_BADCODE = 2'd3
    } alarm_kind_e;

    typedef enum logic {
        SW_PROBE = 1'b0,
        SW_RAISE = 1'b1
    } sweep_state_e;

endpackage

// File: rtl/liveness_table.sv
module liveness_table #(
    parameter int ENTRIES = 256,
    parameter int ADDR_W  = 12,
    parameter int NCODES  = 16,
    parameter int TS_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic [NCODES-1:0] wr_mask,
    input  logic [TS_W-1:0]   now_ts,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [NCODES-1:0] lk_mask,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_idx,
    input  logic [IDX_W-1:0]  sc_idx,
    output logic              sc_valid,
    output logic              sc_armed,
    output logic [ADDR_W-1:0] sc_addr,
    output logic [TS_W-1:0]   sc_seen,
    input  logic              disarm_en
);

    logic [ADDR_W-1:0] addr_q [ENTRIES];
    logic [NCODES-1:0] mask_q [ENTRIES];
    logic [TS_W-1:0]   seen_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] armed_q;

    // flags carry reset; the payload arrays do not need it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            armed_q <= '0;
        end else begin
            if (disarm_en) armed_q[sc_idx] <= 1'b0;
            if (touch_en)  armed_q[touch_idx] <= 1'b1;
            if (wr_en) begin
                valid_q[wr_idx] <= wr_valid;
                armed_q[wr_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (touch_en) seen_q[touch_idx] <= now_ts;
        if (wr_en) begin
            addr_q[wr_idx] <= wr_addr;
            mask_q[wr_idx] <= wr_mask;
            seen_q[wr_idx] <= now_ts;
        end
    end

    // associative lookup, lowest matching index wins
    always_comb begin
        lk_hit = 1'b0;
        lk_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && (addr_q[i] == lk_addr)) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
        end
    end

    assign lk_mask  = mask_q[lk_idx];
    assign sc_valid = valid_q[sc_idx];
    assign sc_armed = armed_q[sc_idx];
    assign sc_addr  = addr_q[sc_idx];
    assign sc_seen  = seen_q[sc_idx];

endmodule

// File: rtl/liveness_sweep.sv
module liveness_sweep
    import liveness_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int TS_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [TS_W-1:0]  now_ts,
    input  logic [TS_W-1:0]  timeout,
    input  logic             sc_valid,
    input  logic             sc_armed,
    input  logic [TS_W-1:0]  sc_seen,
    output logic [IDX_W-1:0] scan_idx,
    output logic             fire
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [TS_W-1:0]  age;
    logic             expired;
    logic             advance;

    assign age     = now_ts - sc_seen;
    assign expired = sc_valid && sc_armed && (age > timeout);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_PROBE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (advance) idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_PROBE: if (!hold && expired) state_d = SW_RAISE;
            SW_RAISE: if (!hold)            state_d = SW_PROBE;
            default:                        state_d = SW_PROBE;
        endcase
    end

    always_comb begin
        advance = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            SW_PROBE: advance = !hold && !expired;
            SW_RAISE: begin
                advance = !hold;
                fire    = !hold && expired;
            end
            default: advance = 1'b0;
        endcase
    end

    assign scan_idx = idx_q;

endmodule

// File: rtl/liveness_fifo.sv
module liveness_fifo #(
    parameter int W     = 46,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         lost
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop, do_push;

    assign valid   = (cnt_q != '0);
    assign do_pop  = pop && valid;
    assign do_push = push && ((cnt_q != FULL_CNT) || do_pop);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            lost  <= 1'b0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push && !do_push) lost <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    assign dout = mem_q[rd_q];

endmodule

// File: rtl/liveness_monitor.sv
module liveness_monitor
    import liveness_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int ADDR_W     = 12,
    parameter int TS_W       = 32,
    parameter int ENTRIES    = 256,
    parameter int FIFO_DEPTH = 8,
    localparam int NCODES    = 1 << CODE_W,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int ALM_W     = 2 + ADDR_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [CODE_W-1:0] frame_code,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [TS_W-1:0]   now_ts,
    input  logic [TS_W-1:0]   timeout,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic              tbl_valid,
    input  logic [NCODES-1:0] tbl_mask,
    input  logic              alm_pop,
    output logic              alm_valid,
    output logic [1:0]        alm_kind,
    output logic [ADDR_W-1:0] alm_addr,
    output logic [TS_W-1:0]   alm_ts,
    output logic              alm_lost
);

    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [NCODES-1:0] lk_mask;
    logic [IDX_W-1:0]  scan_idx;
    logic              sc_valid, sc_armed;
    logic [ADDR_W-1:0] sc_addr;
    logic [TS_W-1:0]   sc_seen;
    logic              off_fire;
    logic              is_unknown, is_badcode, push;
    alarm_kind_e       push_kind;
    logic [ADDR_W-1:0] push_addr;
    logic [TS_W-1:0]   push_ts;
    logic [ALM_W-1:0]  head;

    liveness_table #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .NCODES(NCODES), .TS_W(TS_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_addr(tbl_addr),
        .wr_valid(tbl_valid), .wr_mask(tbl_mask), .now_ts(now_ts),
        .lk_addr(frame_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_mask(lk_mask),
        .touch_en(frame_valid && lk_hit), .touch_idx(lk_idx),
        .sc_idx(scan_idx), .sc_valid(sc_valid), .sc_armed(sc_armed),
        .sc_addr(sc_addr), .sc_seen(sc_seen),
        .disarm_en(off_fire)
    );

    liveness_sweep #(
        .ENTRIES(ENTRIES), .TS_W(TS_W)
    ) u_sweep (
        .clk(clk), .rst_n(rst_n), .hold(frame_valid),
        .now_ts(now_ts), .timeout(timeout),
        .sc_valid(sc_valid), .sc_armed(sc_armed), .sc_seen(sc_seen),
        .scan_idx(scan_idx), .fire(off_fire)
    );

    // frame checks; the sweeper only fires on frame-free cycles
    assign is_unknown = frame_valid && !lk_hit;
    assign is_badcode = frame_valid && lk_hit && !lk_mask[frame_code];
    assign push       = is_unknown || is_badcode || off_fire;

    always_comb begin
        push_kind = ALM_NONE;
        push_addr = frame_addr;
        push_ts   = now_ts;
        if (is_unknown)      push_kind = ALM_UNKNOWN;
        else if (is_badcode) push_kind = ALM_BADCODE;
        else if (off_fire) begin
            push_kind = ALM_OFFLINE;
            push_addr = sc_addr;
            push_ts   = sc_seen;
        end
    end

    liveness_fifo #(
        .W(ALM_W), .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din({push_kind, push_addr, push_ts}),
        .pop(alm_pop), .dout(head), .valid(alm_valid), .lost(alm_lost)
    );

    assign alm_kind = head[ALM_W-1 -: 2];
    assign alm_addr = head[TS_W +: ADDR_W];
    assign alm_ts   = head[TS_W-1:0];

endmodule

// File: rtl/liveness_monitor_chk.sv
module liveness_monitor_chk #(
    parameter int ADDR_W  = 12,
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input logic [ADDR_W-1:0] frame_addr,
    input logic              lk_hit,
    input logic              off_fire,
    input logic [IDX_W-1:0]  scan_idx,
    input logic              alm_pop,
    input logic              alm_valid,
    input logic [1:0]        alm_kind,
    input logic [ADDR_W-1:0] alm_addr,
    input logic              alm_lost
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    a_r10_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alm_lost |=> alm_lost);

    a_r10_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_valid && !alm_pop) |=> alm_valid);

    a_r3_unknown_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !lk_hit && !alm_valid) |=>
            (alm_valid && alm_kind == 2'd2 && alm_addr == $past(frame_addr)));

    a_r9_offline_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        off_fire |-> !frame_valid);

    a_r9_sweep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> $stable(scan_idx));

    a_r9_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scan_idx) |->
            scan_idx == (($past(scan_idx) == LAST_IDX) ? '0 : $past(scan_idx) + 1'b1));

    a_r6_offline_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (off_fire && !alm_valid) |=> (alm_valid && alm_kind == 2'd1));

endmodule

bind liveness_monitor liveness_monitor_chk #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_addr(frame_addr),
    .lk_hit(lk_hit), .off_fire(off_fire), .scan_idx(scan_idx),
    .alm_pop(alm_pop), .alm_valid(alm_valid), .alm_kind(alm_kind),
    .alm_addr(alm_addr), .alm_lost(alm_lost)
);

// File: tb/liveness_monitor_bench.sv
module liveness_monitor_bench;

    localparam int ENT   = 8;
    localparam int FDEP  = 4;
    localparam int IW    = $clog2(ENT);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [3:0]  frame_code = '0;
    logic [11:0] frame_addr = '0;
    logic [31:0] now_ts = '0;
    logic [31:0] timeout = 32'd1000;
    logic        tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [11:0] tbl_addr = '0;
    logic        tbl_valid = 1'b0;
    logic [15:0] tbl_mask = '0;
    logic        alm_pop = 1'b0;
    logic        alm_valid;
    logic [1:0]  alm_kind;
    logic [11:0] alm_addr;
    logic [31:0] alm_ts;
    logic        alm_lost;

    always #4 clk = ~clk;

    liveness_monitor #(.ENTRIES(ENT), .FIFO_DEPTH(FDEP)) u_liveness_monitor (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_code(frame_code),
        .frame_addr(frame_addr), .now_ts(now_ts), .timeout(timeout),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
        .tbl_mask(tbl_mask), .alm_pop(alm_pop), .alm_valid(alm_valid),
        .alm_kind(alm_kind), .alm_addr(alm_addr), .alm_ts(alm_ts), .alm_lost(alm_lost)
    );

    typedef struct {
        logic [1:0]  k;
        logic [11:0] a;
        logic [31:0] t;
    } exp_t;

    exp_t        exp_q[$];
    logic [11:0] m_addr  [ENT];
    logic [15:0] m_mask  [ENT];
    logic [31:0] m_seen  [ENT];
    logic        m_valid [ENT];
    logic        m_armed [ENT];
    logic        m_lost = 1'b0;
    int          checks = 0;
    int          errors = 0;
    logic        live = 1'b0;
    logic        done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic model_push(input logic [1:0] k, input logic [11:0] a, input logic [31:0] t);
        exp_t e;
        e.k = k; e.a = a; e.t = t;
        if (exp_q.size() < FDEP) exp_q.push_back(e);
        else m_lost = 1'b1;
    endtask

    // lost flag compared every clock against the model
    always begin
        @(posedge clk);
        #2;
        if (live) check(alm_lost == m_lost, "R10 lost flag", 64'(alm_lost), 64'(m_lost));
    end

    task automatic set_now(input logic [31:0] v);
        @(negedge clk);
        now_ts = v;
    endtask

    task automatic tbl_write(input int idx, input logic [11:0] a, input logic v, input logic [15:0] m);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_addr = a; tbl_valid = v; tbl_mask = m;
        m_addr[idx] = a; m_valid[idx] = v; m_mask[idx] = m; m_seen[idx] = now_ts; m_armed[idx] = 1'b1;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic frame(input logic [11:0] a, input logic [3:0] c);
        int hit;
        @(negedge clk);
        frame_valid = 1'b1; frame_addr = a; frame_code = c;
        hit = -1;
        for (int i = ENT - 1; i >= 0; i--)
            if (m_valid[i] && m_addr[i] == a) hit = i;
        if (hit < 0) model_push(2'd2, a, now_ts);
        else begin
            m_seen[hit] = now_ts;
            m_armed[hit] = 1'b1;
            if (!m_mask[hit][c]) model_push(2'd3, a, now_ts);
        end
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        for (int i = 0; i < ENT; i++) begin
            if (m_valid[i] && m_armed[i] && ((now_ts - m_seen[i]) > timeout)) begin
                model_push(2'd1, m_addr[i], m_seen[i]);
                m_armed[i] = 1'b0;
            end
        end
    endtask

    task automatic pop_check(input string req);
        exp_t e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
            check(!alm_valid, req, 64'(alm_valid), 64'd0);
        end else if (!alm_valid) begin
            check(1'b0, req, 64'd0, 64'd1);
            void'(exp_q.pop_front());
        end else begin
            e = exp_q.pop_front();
            check(alm_kind == e.k && alm_addr == e.a && alm_ts == e.t, req,
                  {18'd0, alm_kind, alm_addr, alm_ts}, {18'd0, e.k, e.a, e.t});
            alm_pop = 1'b1;
            @(negedge clk);
            alm_pop = 1'b0;
        end
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        check(!alm_valid && exp_q.size() == 0, req, 64'(alm_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_valid[i] = 1'b0; m_armed[i] = 1'b0; m_addr[i] = '0; m_mask[i] = '0; m_seen[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state
        expect_empty("R1 fifo empty after reset");
        check(alm_lost == 1'b0, "R1 lost clear after reset", 64'(alm_lost), 64'd0);

        set_now(32'd0);
        tbl_write(0, 12'h100, 1'b1, 16'h00FF);
        tbl_write(1, 12'h101, 1'b1, 16'h0F0F);
        tbl_write(2, 12'h102, 1'b0, 16'hFFFF);
        idle(40);
        expect_empty("R6 no alarm while young");

        set_now(32'd10);
        frame(12'h0AB, 4'd1);   // R3 unknown address
        frame(12'h101, 4'd4);   // R4 code 4 masked off
        frame(12'h101, 4'd8);   // R4 allowed code
        frame(12'h100, 4'd7);   // allowed
        frame(12'h102, 4'd0);   // R3 invalid entry never matches
        frame(12'h100, 4'd9);   // R4 masked off
        pop_check("R3 unknown address alarm");
        pop_check("R4 bad code alarm");
        pop_check("R3 unregistered entry alarm");
        pop_check("R4 bad code second device");
        expect_empty("R4 allowed codes raise nothing");

        set_now(32'd500);
        frame(12'h101, 4'd8);   // R5 refresh
        set_now(32'd1010);
        idle(40);
        expect_empty("R6 age equal to timeout raises nothing");
        set_now(32'd1011);
        idle(40);
        pop_check("R6 offline alarm with last-heard time");
        idle(40);
        expect_empty("R7 single alarm per episode");
        set_now(32'd1501);
        idle(40);
        pop_check("R5 refreshed device expires later");

        set_now(32'd2000);
        frame(12'h100, 4'd0);
        frame(12'h101, 4'd8);
        set_now(32'd2500);
        frame(12'h101, 4'd8);
        idle(40);
        expect_empty("R5 re-armed devices quiet");
        set_now(32'd3001);
        idle(40);
        pop_check("R7 second episode after re-arm");
        expect_empty("R7 no extra alarm");

        @(negedge clk) timeout = 32'hFFFF_FFFF;
        set_now(32'hFFFF_FF00);
        frame(12'h101, 4'd8);
        idle(20);
        @(negedge clk) timeout = 32'd1000;
        set_now(32'h0000_02E8);
        idle(40);
        expect_empty("R8 wrapped age equal to timeout");
        set_now(32'h0000_02E9);
        idle(40);
        pop_check("R8 wrapped age past timeout");

        tbl_write(3, 12'h103, 1'b1, 16'hFFFF);
        set_now(32'h0000_06D1);
        idle(40);
        expect_empty("R2 write stamps time");
        set_now(32'h0000_06D2);
        idle(40);
        pop_check("R2 silent new entry goes offline");

        set_now(32'd5000);
        for (int i = 0; i < 6; i++) frame(12'h200 + 12'(i), 4'd0);
        for (int i = 0; i < FDEP; i++) pop_check("R10 order under overflow");
        expect_empty("R10 dropped alarms absent");
        check(alm_lost == 1'b1, "R10 lost set on overflow", 64'(alm_lost), 64'd1);
        idle(20);
        check(alm_lost == 1'b1, "R10 lost stays set", 64'(alm_lost), 64'd1);

        done = 1'b1;
        live = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            live = 1'b0;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule